// File: doc/BRIEF.md
# Link Test Pattern Source

This block supplies one 10-bit parallel word per clock to a serial link transmitter, which sends each word as ten serial bits. Three sources are available. A training source alternates between two fixed words so that the far-end receiver can find word boundaries. A replay source loops through eight programmable words. A pseudorandom source produces a maximal-length bit stream of period 2^20-1. A fourth selection holds the output at zero.

All configuration goes in through a serial scan path, not a parallel bus. The configuration is the source selection and the eight stored words. Bits shift into a shadow chain on the scan clock. Nothing reaches the active configuration until an update strobe is pulsed in the main clock domain, so a long shift never disturbs the word stream. The far end of the shadow chain drives the scan output, so a second shift reads back what was loaded.

Top module: `link_pattern_src`

## Requirements
- R1: While `rst` is high, `tx_word` is zero and the training source is selected. The two words after reset release are 10'b0101010100 and then 10'b1010101011.
- R2: While the training source (select code 2'b00) is active, successive words alternate between 10'b0101010100 and 10'b1010101011. The alternation restarts at 10'b0101010100 when the training source becomes selected.
- R3: With select code 2'b01, `tx_word` replays the stored words at indices 0,1,...,7 and then wraps to 0. The index restarts at 0 whenever an update changes the selection.
- R4: With select code 2'b10, words come from a 20-bit generator for x^20+x^17+1 seeded with 20'h5A3C1. Take bits b[n] with b[0..19] equal to seed bits 19 down to 0, and b[n+20] = b[n] xor b[n+3]. Then word w carries b[10w+j] on bit 9-j, so the first bit sits in the MSB. The generator advances only while it is selected, and its state is never all zeros.
- R5: With select code 2'b11, `tx_word` is zero.
- R6: Each rising `scan_clk` edge shifts `scan_di` into chain bit 0 and moves every bit one place up. The chain is 82 bits. Bits [1:0] hold the select code, and bits [2+10i+9 : 2+10i] hold stored word i.
- R7: Shifting the chain without an update pulse has no effect on `tx_word` or on the active selection.
- R8: An update pulse loads the whole chain at the `clk` edge where `scan_update` is high. The word after that edge still comes from the old source, and the next word comes from the new one.
- R9: `scan_do` shows chain bit 81, so shifting 82 further bits returns the loaded vector MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset, seen in both clock domains |
| scan_clk | input | 1 | Scan shift clock |
| scan_di | input | 1 | Serial configuration input |
| scan_update | input | 1 | Copies shadow chain into the active configuration (clk domain) |
| scan_do | output | 1 | Last bit of the shadow chain |
| tx_word | output | 10 | Registered parallel word to the serializer |

## Verification
Every source is loaded from a table whose entries differ in select code and stored words. All-ones and all-zero word bases show whether any bit is stuck, and distinct per-index words show the wrap order of the replay index. The pseudorandom words are compared against a bit recurrence, which exposes a wrong tap, a wrong shift direction or a reversed bit order within the word. Directed cases switch between sources to show that the index and the alternation restart, that an un-updated shift is invisible, and that the readback returns the loaded vector.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_FRAME   = 2'b00,
    SRC_PATTERN = 2'b01,
    SRC_PRBS    = 2'b10,
    SRC_ZERO    = 2'b11
  } src_e;

  localparam logic [9:0] TRAIN_EVEN = 10'b0101010100;
  localparam logic [9:0] TRAIN_ODD  = 10'b1010101011;
endpackage

// File: rtl/lps_scan_shadow.sv
module lps_scan_shadow #(
  parameter int CHAIN_W = 82
) (
  input  logic               scan_clk,
  input  logic               rst,
  input  logic               scan_di,
  output logic [CHAIN_W-1:0] shadow,
  output logic               scan_do
);
  // Shift toward the MSB; new bits enter at bit 0.
  always_ff @(posedge scan_clk) begin
    if (rst) shadow <= '0;
    else     shadow <= {shadow[CHAIN_W-2:0], scan_di};
  end

  assign scan_do = shadow[CHAIN_W-1];
endmodule

// File: rtl/lps_cfg_regs.sv
module lps_cfg_regs
  import lps_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int DEPTH   = 8,
  parameter int PTR_W   = 3,
  parameter int CHAIN_W = 82
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CHAIN_W-1:0] shadow,
  input  logic [PTR_W-1:0]   rd_addr,
  output src_e               sel_act,
  output logic               sel_chg,
  output logic [WORD_W-1:0]  rd_word
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  src_e              sel_new;

  assign sel_new = src_e'(shadow[SEL_W-1:0]);
  assign sel_chg = load && (sel_new != sel_act);

  always_ff @(posedge clk) begin
    if (rst)       sel_act <= SRC_FRAME;
    else if (load) sel_act <= sel_new;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)       mem_q[i] <= '0;
      else if (load) mem_q[i] <= shadow[SEL_W + i*WORD_W +: WORD_W];
    end
  end

  assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/lps_prbs.sv
module lps_prbs #(
  parameter int              LFSR_W = 20,
  parameter int              WORD_W = 10,
  parameter int              TAP_HI = 19,
  parameter int              TAP_LO = 16,
  parameter logic [LFSR_W-1:0] SEED = 20'h5A3C1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [WORD_W-1:0] word,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] nxt;

  // Unroll WORD_W single-bit steps; the oldest bit lands in the word MSB.
  always_comb begin
    nxt  = state;
    word = '0;
    for (int j = 0; j < WORD_W; j++) begin
      word[WORD_W-1-j] = nxt[LFSR_W-1];
      nxt = {nxt[LFSR_W-2:0], nxt[TAP_HI] ^ nxt[TAP_LO]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= nxt;
  end
endmodule

// File: rtl/link_pattern_src.sv
module link_pattern_src
  import lps_pkg::*;
#(
  parameter int              WORD_W = 10,
  parameter int              DEPTH  = 8,
  parameter int              LFSR_W = 20,
  parameter logic [LFSR_W-1:0] SEED = 20'h5A3C1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_clk,
  input  logic              scan_di,
  input  logic              scan_update,
  output logic              scan_do,
  output logic [WORD_W-1:0] tx_word
);
  localparam int               PTR_W   = $clog2(DEPTH);
  localparam int               CHAIN_W = SEL_W + DEPTH*WORD_W;
  localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH-1);

  logic [CHAIN_W-1:0] shadow;
  src_e               sel_act;
  logic               sel_chg;
  logic [PTR_W-1:0]   ptr;
  logic [WORD_W-1:0]  rd_word;
  logic [WORD_W-1:0]  prbs_word;
  logic [LFSR_W-1:0]  prbs_state;
  logic               frame_ph;

  lps_scan_shadow #(.CHAIN_W(CHAIN_W)) u_shadow (
    .scan_clk (scan_clk),
    .rst      (rst),
    .scan_di  (scan_di),
    .shadow   (shadow),
    .scan_do  (scan_do)
  );

  lps_cfg_regs #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CHAIN_W(CHAIN_W)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (scan_update),
    .shadow  (shadow),
    .rd_addr (ptr),
    .sel_act (sel_act),
    .sel_chg (sel_chg),
    .rd_word (rd_word)
  );

  lps_prbs #(
    .LFSR_W(LFSR_W), .WORD_W(WORD_W), .TAP_HI(LFSR_W-1), .TAP_LO(LFSR_W-4),
    .SEED(SEED)
  ) u_prbs (
    .clk   (clk),
    .rst   (rst),
    .adv   (sel_act == SRC_PRBS),
    .word  (prbs_word),
    .state (prbs_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word  <= '0;
      frame_ph <= 1'b0;
      ptr      <= '0;
    end else begin
      unique case (sel_act)
        SRC_FRAME: begin
          tx_word  <= frame_ph ? WORD_W'(TRAIN_ODD) : WORD_W'(TRAIN_EVEN);
          frame_ph <= ~frame_ph;
        end
        SRC_PATTERN: begin
          tx_word <= rd_word;
          ptr     <= (ptr == LAST) ? '0 : ptr + PTR_W'(1);
        end
        SRC_PRBS: tx_word <= prbs_word;
        SRC_ZERO: tx_word <= '0;
      endcase
      if (sel_chg) begin
        frame_ph <= 1'b0;
        ptr      <= '0;
      end
    end
  end
endmodule

// File: rtl/link_pattern_src_chk.sv
module link_pattern_src_chk
  import lps_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int DEPTH  = 8,
  parameter int LFSR_W = 20,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_update,
  input logic [WORD_W-1:0] tx_word,
  input src_e              sel_act,
  input logic              sel_chg,
  input logic [PTR_W-1:0]  ptr,
  input logic [LFSR_W-1:0] prbs_state
);
  p_reset_out_r1: assert property (@(posedge clk) rst |=> tx_word == '0);

  p_frame_alt_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_act == SRC_FRAME && $past(sel_act) == SRC_FRAME &&
     tx_word == WORD_W'(TRAIN_EVEN)) |=> tx_word == WORD_W'(TRAIN_ODD));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_act == SRC_PATTERN && !sel_chg) |=>
      ptr == (($past(ptr) == PTR_W'(DEPTH-1)) ? '0 : $past(ptr) + PTR_W'(1)));

  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (rst)
    prbs_state != '0);

  p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
    sel_act == SRC_ZERO |=> tx_word == '0);

  p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !scan_update |=> $stable(sel_act));
endmodule

bind link_pattern_src link_pattern_src_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .LFSR_W(LFSR_W), .PTR_W(PTR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .scan_update (scan_update),
  .tx_word     (tx_word),
  .sel_act     (sel_act),
  .sel_chg     (sel_chg),
  .ptr         (ptr),
  .prbs_state  (prbs_state)
);

// File: tb/link_pattern_src_tb.sv
module link_pattern_src_tb;
  localparam int CW = 82;
  localparam logic [9:0] WA = 10'b0101010100;
  localparam logic [9:0] WB = 10'b1010101011;
  localparam logic [19:0] SEED = 20'h5A3C1;

  // {select, word base}; stored word i = base + 73*i
  localparam logic [11:0] TBL [5] = '{
    {2'b01, 10'h3FF}, {2'b00, 10'h000}, {2'b10, 10'h000},
    {2'b11, 10'h155}, {2'b01, 10'h0A5}
  };

  logic clk = 0, rst = 1, scan_clk = 0, scan_di = 0, scan_update = 0;
  logic scan_do;
  logic [9:0] tx_word;
  int checks = 0, fails = 0;
  bit done = 0;
  logic bits [0:999];

  link_pattern_src u_dut (
    .clk(clk), .rst(rst), .scan_clk(scan_clk), .scan_di(scan_di),
    .scan_update(scan_update), .scan_do(scan_do), .tx_word(tx_word)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [CW-1:0] cfg(input logic [1:0] sel, input logic [9:0] base);
    logic [CW-1:0] v = '0;
    v[1:0] = sel;
    for (int i = 0; i < 8; i++) v[2 + 10*i +: 10] = base + 10'(73*i);
    return v;
  endfunction

  function automatic logic [9:0] prbs_w(input int w);
    logic [9:0] r;
    for (int j = 0; j < 10; j++) r[9-j] = bits[10*w + j];
    return r;
  endfunction

  task automatic shift(input logic [CW-1:0] v, output logic [CW-1:0] seen);
    for (int k = 0; k < CW; k++) begin
      scan_di = v[CW-1-k];
      #5 seen[CW-1-k] = scan_do;
      scan_clk = 1; #10 scan_clk = 0; #5;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    repeat (2) begin scan_clk = 1; #10 scan_clk = 0; #10; end
    repeat (2) @(negedge clk);
    check("R1 reset output", 82'(tx_word), 82'(0));
    rst = 0;
  endtask

  task automatic do_update();
    @(negedge clk) scan_update = 1;
    @(negedge clk) scan_update = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] seen, v;
    for (int n = 0; n < 20; n++) bits[n] = SEED[19-n];
    for (int n = 20; n < 1000; n++) bits[n] = bits[n-20] ^ bits[n-17];

    // Table-driven pass over all sources (R2 R3 R4 R5 R6 R8)
    for (int e = 0; e < 5; e++) begin
      logic [1:0] sel = TBL[e][11:10];
      logic [9:0] base = TBL[e][9:0];
      do_reset();
      shift(cfg(2'b11, 10'h0), seen);
      do_update();
      shift(cfg(sel, base), seen);
      do_update();
      for (int w = 0; w < 12; w++) begin
        logic [9:0] exp;
        @(negedge clk);
        case (sel)
          2'b00: exp = (w % 2 == 0) ? WA : WB;
          2'b01: exp = base + 10'(73 * (w % 8));
          2'b10: exp = prbs_w(w);
          default: exp = '0;
        endcase
        check(sel == 2'b00 ? "R2 training" : sel == 2'b01 ? "R3 replay R6 layout" :
              sel == 2'b10 ? "R4 prbs" : "R5 zero", 82'(tx_word), 82'(exp));
      end
    end

    // R1: words after reset release
    do_reset();
    @(negedge clk); check("R1 first word", 82'(tx_word), 82'(WA));
    @(negedge clk); check("R1 second word", 82'(tx_word), 82'(WB));

    // R9: readback of loaded vector, shadow empty after reset
    v = cfg(2'b10, 10'h2C5);
    shift(v, seen);
    check("R9 reset chain", seen, '0);
    shift('0, seen);
    check("R9 readback", seen, v);

    // R7 and R8: shift without update leaves output at zero
    do_reset();
    shift(cfg(2'b11, 10'h0), seen);
    do_update();
    shift(cfg(2'b01, 10'h100), seen);
    repeat (3) begin
      @(negedge clk);
      check("R7 no update", 82'(tx_word), 82'(0));
    end
    do_update();
    check("R8 old source one more word", 82'(tx_word), 82'(0));
    @(negedge clk); check("R8 new source", 82'(tx_word), 82'(10'h100));
    @(negedge clk); check("R3 index 1", 82'(tx_word), 82'(10'h100 + 10'd73));

    // R3 restart on selection change, R2 restart of training
    shift(cfg(2'b00, 10'h100), seen);
    do_update();
    @(negedge clk); check("R2 restart", 82'(tx_word), 82'(WA));
    shift(cfg(2'b01, 10'h100), seen);
    do_update();
    @(negedge clk); check("R3 restart index", 82'(tx_word), 82'(10'h100));

    // R4: generator held while others ran; first word from seed
    shift(cfg(2'b10, 10'h0), seen);
    do_update();
    @(negedge clk); check("R4 held while unselected", 82'(tx_word), 82'(prbs_w(0)));
    @(negedge clk); check("R4 second word", 82'(tx_word), 82'(prbs_w(1)));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule